// File: doc/BRIEF.md
# Mode-Selectable Modular Adder

This block adds two unsigned operands and, under a two-bit mode input, returns the result either at full width or reduced to a smaller power-of-two range. At the default width of four bits the ranges are modulo 16, modulo 8 and modulo 4. One shared adder produces the raw sum. A mask then clears the upper result bits that the selected range excludes, and a gate passes the carry-out only in full-width mode.

A small control module decodes the mode into a set of strobes: which top bits to clear and whether the carry may pass. The datapath applies those strobes. A parameter selects the output variant. With the output register on, results and a valid flag appear one clock after the operands are presented, and the outputs hold their value while no new operands arrive. With the register off, the outputs follow the inputs in the same cycle.

Top module: `modadd_top`

## Requirements
- R1: With modeSel = 2'b00, sumOut equals (opA + opB) mod 2^WIDTH and carryOut equals bit WIDTH of the unbounded sum (for WIDTH = 4: 9 + 8 gives sumOut 1, carryOut 1).
- R2: With modeSel = 2'b01, sumOut equals (opA + opB) mod 2^(WIDTH-1), so its top bit is 0 (mod 8 at WIDTH = 4).
- R3: With modeSel = 2'b10, sumOut equals (opA + opB) mod 2^(WIDTH-2), so its top two bits are 0 (mod 4 at WIDTH = 4).
- R4: With modeSel = 2'b11, which is reserved, sumOut equals (opA + opB) mod 2^WIDTH, the same as mode 2'b00.
- R5: carryOut is 0 in every mode other than 2'b00.
- R6: With REG_OUT = 1, the result for operands presented with inValid high in one cycle appears on sumOut and carryOut after the next rising clock edge, and outValid equals inValid delayed by one clock.
- R7: With REG_OUT = 1, a clock edge at which inValid is low leaves sumOut and carryOut unchanged, whatever opA, opB and modeSel carry.
- R8: With REG_OUT = 1, while rstN is low, sumOut, carryOut and outValid are all 0 after a clock edge.
- R9: With REG_OUT = 0, sumOut and carryOut follow the inputs within the same cycle, and outValid equals inValid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Operands and mode are meaningful this cycle |
| opA | input | WIDTH | First unsigned operand |
| opB | input | WIDTH | Second unsigned operand |
| modeSel | input | 2 | Range select: 00 full, 01 drop top bit, 10 drop top two bits, 11 full without carry |
| sumOut | output | WIDTH | Range-reduced sum |
| carryOut | output | 1 | Carry-out of the addition, in mode 00 only |
| outValid | output | 1 | sumOut and carryOut hold a fresh result |

## Verification
On every cycle, the assertions compare each valid output with the unbounded sum of the operands that produced it, checking the cleared top bits per mode, the carry gating outside full mode, the one-cycle lag of the valid flag and the hold behaviour of the register. Only the bench's scenarios can show the exact values for all 256 operand pairs in each of the four modes on both output variants. The same holds for the state at reset and for the outputs staying put while inValid is low.

// File: rtl/modadd_pkg.sv
package modadd_pkg;

  typedef enum logic [1:0] {
    MODE_FULL = 2'b00,
    MODE_DROP1 = 2'b01,
    MODE_DROP2 = 2'b10,
    MODE_NOCARRY = 2'b11
  } modeSel_e;

  typedef struct packed {
    logic carryEn;
    logic clrTop1;
    logic clrTop2;
  } ctlStrobes_t;

endpackage

// File: rtl/modadd_ctrl.sv
module modadd_ctrl
  import modadd_pkg::*;
(
  input  logic [1:0]  modeSel,
  output ctlStrobes_t strobes
);

  modeSel_e modeDec;

  always_comb begin
    modeDec = modeSel_e'(modeSel);
    strobes = '0;
    unique case (modeDec)
      MODE_FULL:    strobes.carryEn = 1'b1;
      MODE_DROP1:   strobes.clrTop1 = 1'b1;
      MODE_DROP2:   strobes.clrTop2 = 1'b1;
      MODE_NOCARRY: strobes = '0;
      default:      strobes = '0;
    endcase
  end

endmodule

// File: rtl/modadd_dpath.sv
module modadd_dpath
  import modadd_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  ctlStrobes_t      strobes,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut,
  output logic             outValid
);

  localparam int SUM_W = WIDTH + 1;

  logic [SUM_W-1:0] rawSum;
  logic [WIDTH-1:0] keepMask;
  logic [WIDTH-1:0] maskedSum;
  logic             gatedCarry;

  assign rawSum = {1'b0, opA} + {1'b0, opB};

  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    if (i == WIDTH - 1) begin : g_top
      assign keepMask[i] = ~(strobes.clrTop1 | strobes.clrTop2);
    end else if (i == WIDTH - 2) begin : g_next
      assign keepMask[i] = ~strobes.clrTop2;
    end else begin : g_low
      assign keepMask[i] = 1'b1;
    end
  end

  assign maskedSum  = rawSum[WIDTH-1:0] & keepMask;
  assign gatedCarry = rawSum[WIDTH] & strobes.carryEn;

  if (REG_OUT) begin : g_reg
    logic [WIDTH-1:0] sumQ;
    logic             carryQ;
    logic             validQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        sumQ   <= '0;
        carryQ <= 1'b0;
        validQ <= 1'b0;
      end else begin
        validQ <= inValid;
        if (inValid) begin
          sumQ   <= maskedSum;
          carryQ <= gatedCarry;
        end
      end
    end

    assign sumOut   = sumQ;
    assign carryOut = carryQ;
    assign outValid = validQ;
  end else begin : g_comb
    assign sumOut   = maskedSum;
    assign carryOut = gatedCarry;
    assign outValid = inValid;
  end

endmodule

// File: rtl/modadd_top.sv
module modadd_top
  import modadd_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [1:0]       modeSel,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut,
  output logic             outValid
);

  ctlStrobes_t strobes;

  modadd_ctrl u_ctrl (
    .modeSel (modeSel),
    .strobes (strobes)
  );

  modadd_dpath #(
    .WIDTH   (WIDTH),
    .REG_OUT (REG_OUT)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .sumOut   (sumOut),
    .carryOut (carryOut),
    .outValid (outValid)
  );

endmodule

// File: rtl/modadd_chk.sv
module modadd_chk #(
  parameter int WIDTH   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [1:0]       modeSel,
  input logic [WIDTH-1:0] sumOut,
  input logic             carryOut,
  input logic             outValid
);

  logic [1:0]     obsMode;
  logic [WIDTH:0] obsSum;

  if (REG_OUT) begin : g_obs_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        obsMode <= 2'b00;
        obsSum  <= '0;
      end else if (inValid) begin
        obsMode <= modeSel;
        obsSum  <= {1'b0, opA} + {1'b0, opB};
      end
    end

    AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> outValid); // R6
    AST_IDLE_LAG: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> !outValid); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> ($stable(sumOut) && $stable(carryOut))); // R7
  end else begin : g_obs_comb
    assign obsMode = modeSel;
    assign obsSum  = {1'b0, opA} + {1'b0, opB};

    AST_VALID_PASS: assert property (@(posedge clk) disable iff (!rstN)
      outValid == inValid); // R9
  end

  AST_FULL_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && obsMode == 2'b00) |-> ({carryOut, sumOut} == obsSum)); // R1
  AST_DROP1_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && obsMode == 2'b01) |-> (sumOut == {1'b0, obsSum[WIDTH-2:0]})); // R2
  AST_DROP2_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && obsMode == 2'b10) |-> (sumOut == {2'b00, obsSum[WIDTH-3:0]})); // R3
  AST_RSVD_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && obsMode == 2'b11) |-> (sumOut == obsSum[WIDTH-1:0])); // R4
  AST_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && obsMode != 2'b00) |-> !carryOut); // R5

endmodule

bind modadd_top modadd_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/modadd_top_tb.sv
module modadd_top_tb;

  localparam int W = 4;

  // vector layout: {mode[1:0], a[3:0], b[3:0], carry, sum[3:0]}
  localparam logic [14:0] VECS [12] = '{
    {2'b00, 4'h9, 4'h8, 1'b1, 4'h1},
    {2'b00, 4'hF, 4'hF, 1'b1, 4'hE},
    {2'b00, 4'h3, 4'h4, 1'b0, 4'h7},
    {2'b00, 4'h0, 4'h0, 1'b0, 4'h0},
    {2'b01, 4'h9, 4'h8, 1'b0, 4'h1},
    {2'b01, 4'h7, 4'h1, 1'b0, 4'h0},
    {2'b01, 4'hF, 4'hF, 1'b0, 4'h6},
    {2'b10, 4'hF, 4'hF, 1'b0, 4'h2},
    {2'b10, 4'h5, 4'h6, 1'b0, 4'h3},
    {2'b10, 4'h2, 4'h2, 1'b0, 4'h0},
    {2'b11, 4'h9, 4'h8, 1'b0, 4'h1},
    {2'b11, 4'h7, 4'h6, 1'b0, 4'hD}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [1:0]   modeSel = 2'b00;
  logic [W-1:0] sumReg, sumComb;
  logic         carryReg, carryComb, validReg, validComb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  modadd_top #(.WIDTH(W), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .modeSel(modeSel), .sumOut(sumReg), .carryOut(carryReg), .outValid(validReg)
  );

  modadd_top #(.WIDTH(W), .REG_OUT(1'b0)) u_comb (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .modeSel(modeSel), .sumOut(sumComb), .carryOut(carryComb), .outValid(validComb)
  );

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [4:0] refModel(input logic [3:0] a, input logic [3:0] b,
                                          input logic [1:0] m);
    int total;
    total = int'(a) + int'(b);
    case (m)
      2'b00:   return 5'(total);
      2'b01:   return {1'b0, 4'(total % 8)};
      2'b10:   return {1'b0, 4'(total % 4)};
      default: return {1'b0, 4'(total % 16)};
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, check the combinational copy, then the registered one a cycle later
  task automatic applyVec(input logic [1:0] m, input logic [3:0] a, input logic [3:0] b,
                          input logic [4:0] exp);
    @(negedge clk);
    modeSel = m; opA = a; opB = b; inValid = 1'b1;
    #1;
    check({modeTag(m), " comb sum"}, int'(sumComb), int'(exp[3:0]));
    check({modeTag(m), " comb carry"}, int'(carryComb), int'(exp[4]));
    if (m != 2'b00) check("R5 comb carry", int'(carryComb), 0);
    check("R9 comb valid", int'(validComb), 1);
    @(negedge clk);
    check({modeTag(m), " reg sum"}, int'(sumReg), int'(exp[3:0]));
    check({modeTag(m), " reg carry"}, int'(carryReg), int'(exp[4]));
    check("R6 reg valid", int'(validReg), 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [3:0] heldSum;
    logic       heldCarry;

    opA = 4'hF; opB = 4'hF; inValid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset sum", int'(sumReg), 0);
    check("R8 reset carry", int'(carryReg), 0);
    check("R8 reset valid", int'(validReg), 0);
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < 12; i++) begin
      applyVec(VECS[i][14:13], VECS[i][12:9], VECS[i][8:5], VECS[i][4:0]);
    end

    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          applyVec(2'(m), 4'(a), 4'(b), refModel(4'(a), 4'(b), 2'(m)));
        end
      end
    end

    // hold while idle: load 9+8 in full mode, then change inputs with inValid low
    applyVec(2'b00, 4'h9, 4'h8, 5'h11);
    heldSum = sumReg;
    heldCarry = carryReg;
    @(negedge clk);
    inValid = 1'b0; opA = 4'h2; opB = 4'h3; modeSel = 2'b10;
    #1;
    check("R9 comb valid low", int'(validComb), 0);
    check("R9 comb follows", int'(sumComb), 1);
    @(negedge clk);
    check("R6 reg valid low", int'(validReg), 0);
    repeat (3) @(negedge clk);
    check("R7 held sum", int'(sumReg), int'(heldSum));
    check("R7 held carry", int'(carryReg), int'(heldCarry));
    check("R7 held sum value", int'(sumReg), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule